// File: doc/BRIEF.md
# I2C Display-Memory Write Receiver

This block is a write-only I2C slave. It sits between a host controller and a display memory that is organised as rows and columns of 16-bit words. The bus lines are sampled on the system clock. The block recognises START and STOP conditions and accepts only transfers addressed to its own device byte. It acknowledges every byte it accepts by pulling SDA low through an open-drain enable.

Each accepted transfer carries three things in order. First comes a pointer byte that selects the row. Next comes a pointer byte that selects the column. Then come any number of data words, each sent as a high byte followed by a low byte. Each completed word is presented on a synchronous write port as row, column, data and a one-cycle strobe. The column then steps forward, so a stream of words fills one row from left to right. Character words, per-row attribute words in column 30 and frame-control words in row 15 all travel through the same path.

Top module: `i2c_dispmem_wr`

## Requirements
- R1: After reset, `sda_oe`, `wr_en`, `wr_row`, `wr_col` and `wr_data` are all 0.
- R2: After START, a first byte of 0xBA (device address 0x5D, write bit 0) is acknowledged. Any other first byte, including 0xBB, is not acknowledged. After such a byte, no later byte is acknowledged and no write is issued until the next START.
- R3: The first byte after the address byte sets the row from its bits 3:0. Bits 7:4 have no effect.
- R4: The second byte after the address byte sets the column from its bits 4:0. Bits 7:5 have no effect.
- R5: Every byte of an accepted transfer is acknowledged. SDA is held low for the whole of the ninth SCL high period of each of these bytes: the address byte, both pointer bytes and every data byte.
- R6: Each data word is formed from two bytes, the first received as bits 15:8 and the second as bits 7:0 of `wr_data`.
- R7: `wr_en` pulses high for exactly one system clock per completed word. The pulse comes after the acknowledge slot of the word's second byte ends, while SCL is low.
- R8: After each write, the column advances by one and the row stays the same. Consecutive words therefore land in consecutive columns.
- R9: The column saturates at 31. Every word after the one written to column 31 is also written to column 31.
- R10: A STOP received after the first byte of a word, and before its second byte, discards that word. No write is issued.
- R11: A repeated START received in the middle of a word discards that word. The new transfer is then handled from its address byte onward.
- R12: Row 15 and column 30 are written through the same path as any other location, with no special handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | I2C clock line as seen on the bus |
| sda_in | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | When 1, the pad pulls SDA low (acknowledge) |
| wr_en | output | 1 | One-cycle write strobe |
| wr_row | output | 4 | Row of the word being written |
| wr_col | output | 5 | Column of the word being written |
| wr_data | output | 16 | Word being written |

## Verification
The bus inputs pass through two synchronizer stages and one edge stage. Every response therefore appears in the third system clock after the bench moves SCL. The acknowledge pull-down rises three clocks after the falling edge that ends the eighth bit. It is released three clocks after the falling edge that ends the ninth bit, in the same cycle that `wr_en` pulses for the second byte of a word. The bench holds each SCL level for ten clocks per quarter bit. It samples the acknowledge in the middle of the ninth SCL high period. Write strobes are collected on falling clock edges and compared with the expected row, column and data only after the STOP condition has completed.

// File: rtl/i2c_dispmem_wr.sv
module i2c_dispmem_wr #(
  parameter logic [6:0] DEV_ADDR = 7'h5D,
  parameter int ROW_W = 4,
  parameter int COL_W = 5,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [WORD_W-1:0] wr_data
);
  localparam int BYTE_W = WORD_W / 2;
  localparam logic [7:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [COL_W-1:0] COL_LAST = '1;

  typedef enum logic [1:0] {S_IDLE, S_RX, S_ACK, S_SKIP} st_t;
  typedef enum logic [2:0] {P_DEV, P_ROW, P_COL, P_DHI, P_DLO} ph_t;

  logic [2:0] scl_p, sda_p;
  st_t        st;
  ph_t        ph;
  logic [3:0] cnt;
  logic [7:0] sr;
  logic [BYTE_W-1:0] hi_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;

  wire scl_s = scl_p[1];
  wire scl_d = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_d = sda_p[2];
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  wire rise_c  = scl_s & ~scl_d;
  wire fall_c  = ~scl_s & scl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= P_DEV;
      cnt     <= '0;
      sr      <= '0;
      hi_q    <= '0;
      row_q   <= '0;
      col_q   <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_row  <= '0;
      wr_col  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        st     <= S_RX;
        ph     <= P_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        ph     <= P_DEV;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (rise_c && cnt != 4'd8) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (fall_c && cnt == 4'd8) begin
              if (ph == P_DEV && sr != ADDR_BYTE) begin
                st <= S_SKIP;
              end else begin
                sda_oe <= 1'b1;
                st     <= S_ACK;
              end
            end
          end
          S_ACK: begin
            if (fall_c) begin
              sda_oe <= 1'b0;
              st     <= S_RX;
              cnt    <= '0;
              case (ph)
                P_DEV: ph <= P_ROW;
                P_ROW: begin
                  row_q <= sr[ROW_W-1:0];
                  ph    <= P_COL;
                end
                P_COL: begin
                  col_q <= sr[COL_W-1:0];
                  ph    <= P_DHI;
                end
                P_DHI: begin
                  hi_q <= sr;
                  ph   <= P_DLO;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_row  <= row_q;
                  wr_col  <= col_q;
                  wr_data <= {hi_q, sr};
                  if (col_q != COL_LAST) col_q <= col_q + 1'b1;
                  ph <= P_DHI;
                end
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_dispmem_wr_chk.sv
module i2c_dispmem_wr_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_oe,
  input logic wr_en
);
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  a_r7_strobe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !scl_in);

  a_r7_strobe_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !sda_oe);

  a_r5_ack_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_in);

  a_r5_ack_ends_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_in);
endmodule

bind i2c_dispmem_wr i2c_dispmem_wr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe), .wr_en(wr_en)
);

// File: tb/i2c_dispmem_wr_test.sv
module i2c_dispmem_wr_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_en;
  logic [3:0] wr_row;
  logic [4:0] wr_col;
  logic [15:0] wr_data;
  wire sda_bus = sda_m & ~sda_oe;

  int nchk = 0;
  int nfail = 0;
  int wcnt = 0;
  bit done = 0;
  logic [3:0]  lrow [64];
  logic [4:0]  lcol [64];
  logic [15:0] ldat [64];

  always #5 clk = ~clk;

  i2c_dispmem_wr uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      lrow[wcnt[5:0]] = wr_row;
      lcol[wcnt[5:0]] = wr_col;
      ldat[wcnt[5:0]] = wr_data;
      wcnt = wcnt + 1;
    end
  end

  // row byte, column byte, high, low, expected row, expected column
  localparam logic [47:0] VEC [0:5] = '{
    48'hF3_A4_12_34_03_04,
    48'h00_00_00_00_00_00,
    48'h0F_02_BE_EF_0F_02,
    48'h0E_1E_55_AA_0E_1E,
    48'h7A_FF_80_01_0A_1F,
    48'h01_E1_FF_FF_01_01
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = v[i]; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    acked = ~sda_bus; wq();
    acked = acked & ~sda_bus;
    scl_m = 1'b0; wq();
  endtask

  task automatic send_acked(input logic [7:0] v, input string req);
    bit a;
    send_byte(v, a);
    chk(a, req, {31'd0, a}, 32'd1);
  endtask

  task automatic open_xfer(input logic [7:0] rb, input logic [7:0] cb);
    bus_start();
    send_acked(8'hBA, "R2");
    send_acked(rb, "R5");
    send_acked(cb, "R5");
  endtask

  task automatic send_word(input logic [15:0] w);
    send_acked(w[15:8], "R5");
    send_acked(w[7:0], "R5");
  endtask

  task automatic expect_write(input int idx, input logic [3:0] r, input logic [4:0] c, input logic [15:0] d, input string req);
    chk(lrow[idx] == r, req, {28'd0, lrow[idx]}, {28'd0, r});
    chk(lcol[idx] == c, req, {27'd0, lcol[idx]}, {27'd0, c});
    chk(ldat[idx] == d, req, {16'd0, ldat[idx]}, {16'd0, d});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int w0;
    bit a;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1", {31'd0, sda_oe}, 32'd0);
    chk(wr_en == 1'b0, "R1", {31'd0, wr_en}, 32'd0);
    chk({wr_row, wr_col, wr_data} == '0, "R1", {7'd0, wr_row, wr_col, wr_data}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table: single-word transfers (R3, R4, R6, R12)
    for (int i = 0; i < 6; i++) begin
      w0 = wcnt;
      open_xfer(VEC[i][47:40], VEC[i][39:32]);
      send_word(VEC[i][31:16]);
      bus_stop();
      chk(wcnt - w0 == 1, "R7", wcnt - w0, 1);
      expect_write(w0, VEC[i][11:8], VEC[i][4:0], VEC[i][31:16], "R3 R4 R6 R12");
    end

    // R2 wrong address: no ack, later bytes ignored
    w0 = wcnt;
    bus_start();
    send_byte(8'hBC, a);
    chk(!a, "R2", {31'd0, a}, 32'd0);
    send_byte(8'h02, a);
    chk(!a, "R2", {31'd0, a}, 32'd0);
    send_byte(8'h03, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    chk(!a, "R2", {31'd0, a}, 32'd0);
    bus_stop();
    chk(wcnt == w0, "R2", wcnt, w0);

    // R2 read bit set is not accepted
    bus_start();
    send_byte(8'hBB, a);
    chk(!a, "R2", {31'd0, a}, 32'd0);
    bus_stop();
    chk(wcnt == w0, "R2", wcnt, w0);

    // R8 consecutive words advance the column
    w0 = wcnt;
    open_xfer(8'h06, 8'h03);
    send_word(16'h1111);
    send_word(16'h2222);
    send_word(16'h3333);
    bus_stop();
    chk(wcnt - w0 == 3, "R8", wcnt - w0, 3);
    expect_write(w0,     4'd6, 5'd3, 16'h1111, "R8");
    expect_write(w0 + 1, 4'd6, 5'd4, 16'h2222, "R8");
    expect_write(w0 + 2, 4'd6, 5'd5, 16'h3333, "R8");

    // R9 saturation at column 31
    w0 = wcnt;
    open_xfer(8'h09, 8'h1E);
    send_word(16'hA001);
    send_word(16'hA002);
    send_word(16'hA003);
    bus_stop();
    chk(wcnt - w0 == 3, "R9", wcnt - w0, 3);
    expect_write(w0,     4'd9, 5'd30, 16'hA001, "R9");
    expect_write(w0 + 1, 4'd9, 5'd31, 16'hA002, "R9");
    expect_write(w0 + 2, 4'd9, 5'd31, 16'hA003, "R9");

    // R10 STOP after high byte discards the word
    w0 = wcnt;
    open_xfer(8'h04, 8'h08);
    send_word(16'h5A5A);
    send_acked(8'hC3, "R5");
    bus_stop();
    chk(wcnt - w0 == 1, "R10", wcnt - w0, 1);
    expect_write(w0, 4'd4, 5'd8, 16'h5A5A, "R10");

    // R11 repeated START mid-word, then a clean transfer
    w0 = wcnt;
    open_xfer(8'h02, 8'h05);
    send_acked(8'hAA, "R5");
    open_xfer(8'h03, 8'h07);
    send_word(16'h1234);
    bus_stop();
    chk(wcnt - w0 == 1, "R11", wcnt - w0, 1);
    expect_write(w0, 4'd3, 5'd7, 16'h1234, "R11");

    // R12 frame-control row and attribute column in one burst
    w0 = wcnt;
    open_xfer(8'h0F, 8'h1E);
    send_word(16'hCAFE);
    bus_stop();
    expect_write(w0, 4'd15, 5'd30, 16'hCAFE, "R12");
    chk(sda_oe == 1'b0 && wr_en == 1'b0, "R7", {30'd0, sda_oe, wr_en}, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule